// File: doc/BRIEF.md
# Bulk Register-Write Command Decoder

This block takes a byte stream of framed bulk commands and turns the register-write commands it finds into a small file of 8-bit display-controller settings. Every command begins with the prefix byte 0xAF, followed by a one-byte command code. A register-write command then carries two more bytes: the register index, then the value. Multi-byte settings are spread over neighbouring indices. A 24-bit base address takes three registers, with its top byte at the lowest index. Most 16-bit settings put the high byte first. The pixel-clock count, in 5 kHz steps, puts the low byte first. This block stores bytes and does not reassemble them, so the byte order matters only to whoever reads the outputs.

A write of a lock value to a control index opens a configuration group. While the group is open, writes go to shadow storage only and the visible registers hold still. A write of the unlock value to the same index copies every shadow into the visible registers in one cycle and pulses a commit strobe, so a set of timing values takes effect together. When no group is open, a write updates both the shadow and the visible register. Stray bytes between commands, a lone prefix that ends a buffer, and commands with unknown codes are all absorbed without effect.

The parser is a five-state machine. IDLE waits for a prefix and drops anything else (IDLE→CODE on 0xAF). CODE reads the command code: a repeated prefix stays in CODE, the write code goes to INDEX, and any other code goes to SKIP. INDEX latches the index and moves to VALUE. VALUE issues the write and returns to IDLE. SKIP discards bytes until a prefix arrives (SKIP→CODE). The input is always ready, and a byte counts only in a cycle where valid is high.

Top module: `bulk_wr_decoder`

## Requirements
- R1: After reset all registers read zero, the commit strobe is low, no group is open and in_ready is high.
- R2: With no group open, the sequence 0xAF, write code (default 0x20), index, value sets that register to the value, visible in the cycle after the clock edge that accepts the value byte.
- R3: In IDLE, any byte other than 0xAF is dropped and changes no register.
- R4: A command code other than the write code and 0xAF makes the parser discard bytes up to the next 0xAF, which then starts a new command.
- R5: A lone 0xAF followed by another 0xAF leaves the parser expecting a command code. A lone 0xAF on its own changes nothing.
- R6: After the value LOCK_VAL (default 0x00) is written to index CTRL_IDX (default 0x00), further writes do not change the visible registers.
- R7: Writing UNLOCK_VAL (default 0xFF) to CTRL_IDX while a group is open copies all staged values in the same edge and raises commit_o for exactly one cycle, right after that edge.
- R8: UNLOCK_VAL written when no group is open raises no commit and changes no register.
- R9: A write to an index at or above NREG (default 64), or to CTRL_IDX, changes no register, and the CTRL_IDX entry always reads zero.
- R10: Cycles with in_valid low are ignored whatever in_data holds, and gaps between the bytes of a command are allowed.
- R11: Index and value bytes equal to 0xAF are taken as data, not as a prefix.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Always high: a byte is taken in any cycle where valid is high |
| regs_o | output | NREG*8 | Visible registers, entry i at bits [8i+7:8i] |
| commit_o | output | 1 | One-cycle pulse after a staged group is committed |

## Verification
Register updates and the commit strobe both come from the edge that accepts the value byte, so both are due one cycle after it. The bench drives each byte on a falling edge and drops valid on the next falling edge, then compares every register and the strobe at that point, half a cycle after the active edge. A further sample one cycle later confirms that the strobe has fallen. Expected values come from a bench-side model of staging and locking that is updated per command.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CODE,
        ST_INDEX,
        ST_VALUE,
        ST_SKIP
    } prs_state_e;
endpackage

// File: rtl/bwd_parser.sv
module bwd_parser
    import bwd_pkg::*;
#(
    parameter logic [7:0] PREFIX  = 8'hAF,
    parameter logic [7:0] WR_CODE = 8'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_val
);
    prs_state_e state_q, state_d;
    logic [7:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid && state_q == ST_INDEX) idx_q <= in_data;
        end
    end

    always_comb begin
        state_d = state_q;
        wr_en   = 1'b0;
        if (in_valid) begin
            unique case (state_q)
                ST_IDLE:  if (in_data == PREFIX) state_d = ST_CODE;
                ST_CODE: begin
                    if (in_data == PREFIX)       state_d = ST_CODE;
                    else if (in_data == WR_CODE) state_d = ST_INDEX;
                    else                         state_d = ST_SKIP;
                end
                ST_INDEX: state_d = ST_VALUE;
                ST_VALUE: begin
                    wr_en   = 1'b1;
                    state_d = ST_IDLE;
                end
                ST_SKIP:  if (in_data == PREFIX) state_d = ST_CODE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    assign wr_idx = idx_q;
    assign wr_val = in_data;
endmodule

// File: rtl/bwd_stage.sv
module bwd_stage #(
    parameter int unsigned NREG       = 64,
    parameter logic [7:0]  CTRL_IDX   = 8'h00,
    parameter logic [7:0]  LOCK_VAL   = 8'h00,
    parameter logic [7:0]  UNLOCK_VAL = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_idx,
    input  logic [7:0]        wr_val,
    output logic [NREG*8-1:0] regs_o,
    output logic              commit_o,
    output logic              locked_o
);
    logic locked_q, commit_q;
    logic ctrl_wr, data_wr, do_lock, do_commit;

    assign ctrl_wr   = wr_en && (wr_idx == CTRL_IDX);
    assign data_wr   = wr_en && (wr_idx != CTRL_IDX) && (32'(wr_idx) < NREG);
    assign do_lock   = ctrl_wr && (wr_val == LOCK_VAL);
    assign do_commit = ctrl_wr && (wr_val == UNLOCK_VAL) && locked_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            commit_q <= 1'b0;
        end else begin
            commit_q <= do_commit;
            if (do_lock)        locked_q <= 1'b1;
            else if (do_commit) locked_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        logic [7:0] sh_q, act_q;
        logic       hit;
        assign hit = data_wr && (wr_idx == 8'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_q  <= '0;
                act_q <= '0;
            end else begin
                if (hit) sh_q <= wr_val;
                if (do_commit)             act_q <= sh_q;
                else if (hit && !locked_q) act_q <= wr_val;
            end
        end
        assign regs_o[g*8 +: 8] = act_q;
    end

    assign commit_o = commit_q;
    assign locked_o = locked_q;
endmodule

// File: rtl/bulk_wr_decoder.sv
module bulk_wr_decoder #(
    parameter int unsigned NREG       = 64,
    parameter logic [7:0]  PREFIX     = 8'hAF,
    parameter logic [7:0]  WR_CODE    = 8'h20,
    parameter logic [7:0]  CTRL_IDX   = 8'h00,
    parameter logic [7:0]  LOCK_VAL   = 8'h00,
    parameter logic [7:0]  UNLOCK_VAL = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic [NREG*8-1:0] regs_o,
    output logic              commit_o
);
    logic       wr_en;
    logic [7:0] wr_idx, wr_val;
    logic       locked_w;

    assign in_ready = 1'b1;

    bwd_parser #(.PREFIX(PREFIX), .WR_CODE(WR_CODE)) u_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val)
    );

    bwd_stage #(
        .NREG(NREG), .CTRL_IDX(CTRL_IDX), .LOCK_VAL(LOCK_VAL), .UNLOCK_VAL(UNLOCK_VAL)
    ) u_stage (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
        .regs_o(regs_o), .commit_o(commit_o), .locked_o(locked_w)
    );
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
    parameter int unsigned NREG       = 64,
    parameter logic [7:0]  UNLOCK_VAL = 8'hFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [7:0]        in_data,
    input logic [NREG*8-1:0] regs_o,
    input logic              commit_o,
    input logic              locked
);
    // R5 R6: with a group open, visible registers move only together with a commit
    a_r6_hold_while_locked: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (commit_o || $stable(regs_o)));

    // R7: the strobe is a single-cycle pulse
    a_r7_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);

    // R7: a commit follows an accepted unlock value byte
    a_r7_commit_cause: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(in_valid && in_data == UNLOCK_VAL));

    // R7: a commit closes the group
    a_r7_unlocked_after: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> !locked);

    // R10: registers change only after an accepted byte
    a_r10_change_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> $past(in_valid));
endmodule

bind bulk_wr_decoder bwd_checker #(.NREG(NREG), .UNLOCK_VAL(UNLOCK_VAL)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .regs_o(regs_o), .commit_o(commit_o), .locked(locked_w)
);

// File: tb/sim_bulk_wr_decoder.sv
`timescale 1ns/1ps
module sim_bulk_wr_decoder;
    localparam int NREG = 64;
    localparam logic [7:0] PFX = 8'hAF, WRC = 8'h20, CTRL = 8'h00, LCK = 8'h00, ULK = 8'hFF;

    logic clk = 0, rst_n = 0, in_valid = 0;
    logic [7:0] in_data = 0;
    logic in_ready, commit_o;
    logic [NREG*8-1:0] regs_o;

    int checks = 0, fails = 0;
    logic [7:0] m_act [NREG];
    logic [7:0] m_sh [NREG];
    bit m_lock, m_commit;

    always #2.5 clk = ~clk;

    bulk_wr_decoder u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .regs_o(regs_o), .commit_o(commit_o));

    function automatic void model_wr(logic [7:0] idx, logic [7:0] val);
        m_commit = 0;
        if (idx == CTRL) begin
            if (val == LCK) m_lock = 1;
            else if (val == ULK && m_lock) begin
                for (int i = 0; i < NREG; i++) m_act[i] = m_sh[i];
                m_lock = 0;
                m_commit = 1;
            end
        end else if (int'(idx) < NREG) begin
            m_sh[idx] = val;
            if (!m_lock) m_act[idx] = val;
        end
    endfunction

    task automatic check(string req, bit exp_commit);
        int bad = -1;
        for (int i = 0; i < NREG; i++)
            if (bad < 0 && regs_o[i*8 +: 8] !== m_act[i]) bad = i;
        checks++;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s reg[%0d] actual %h expected %h", req, bad, regs_o[bad*8 +: 8], m_act[bad]);
        end
        checks++;
        if (commit_o !== exp_commit) begin
            fails++;
            $display("FAIL %s commit actual %b expected %b", req, commit_o, exp_commit);
        end
    endtask

    task automatic send(logic [7:0] b);
        @(negedge clk); in_valid = 1; in_data = b;
        @(negedge clk); in_valid = 0;
    endtask

    task automatic wr(logic [7:0] idx, logic [7:0] val, string req);
        send(PFX); send(WRC); send(idx); send(val);
        model_wr(idx, val);
        check(req, m_commit);
        if (m_commit) begin
            @(negedge clk);
            check({req, " pulse end"}, 0);
        end
    endtask

    function automatic logic [7:0] non_pfx(logic [7:0] b);
        return (b == PFX) ? 8'h00 : b;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NREG; i++) begin m_act[i] = 0; m_sh[i] = 0; end
        m_lock = 0;
        repeat (3) @(negedge clk);
        check("R1 reset", 0);
        checks++;
        if (in_ready !== 1'b1) begin fails++; $display("FAIL R1 in_ready actual %b expected 1", in_ready); end
        rst_n = 1;

        wr(8'd3, 8'h5A, "R2 direct write");
        wr(8'd63, 8'hC3, "R2 top index");
        // R3: idle junk that looks like a write body
        send(WRC); send(8'd10); send(8'h55);
        check("R3 idle junk dropped", 0);
        // R4: unknown code then a write-shaped tail, then a real command
        send(PFX); send(8'h55); send(WRC); send(8'd5); send(8'h11);
        check("R4 skipped bytes", 0);
        wr(8'd6, 8'h22, "R4 resync after skip");
        // R5: double prefix, then lone prefix
        send(PFX); send(PFX); send(WRC); send(8'd7); send(8'h33);
        model_wr(8'd7, 8'h33);
        check("R5 repeated prefix", 0);
        send(PFX);
        check("R5 lone prefix", 0);
        // R11: value equal to prefix
        wr(8'd9, 8'hAF, "R11 value 0xAF");
        wr(8'hAF, 8'h44, "R11 R9 index 0xAF out of range");
        wr(8'd64, 8'h12, "R9 index at NREG");
        // R10: invalid cycles with prefix on the data lines, gapped command
        @(negedge clk); in_data = PFX; repeat (4) @(negedge clk);
        send(PFX); repeat (3) @(negedge clk);
        send(WRC); repeat (2) @(negedge clk);
        send(8'd12); @(negedge clk);
        send(8'h77);
        model_wr(8'd12, 8'h77);
        check("R10 gaps and invalid data", 0);
        // R8: unlock while not locked
        wr(CTRL, ULK, "R8 unlock when open");
        // R6/R7: staged group
        wr(CTRL, LCK, "R6 lock");
        wr(8'd20, 8'h01, "R6 staged hi");
        wr(8'd21, 8'h02, "R6 staged mid");
        wr(8'd22, 8'h03, "R6 staged lo");
        wr(CTRL, 8'h42, "R9 other control value");
        wr(CTRL, ULK, "R7 commit");
        wr(CTRL, LCK, "R6 relock");
        wr(8'd3, 8'hEE, "R6 staged overwrite");
        wr(CTRL, ULK, "R7 second commit");

        for (int n = 0; n < 300; n++) begin
            int op = $urandom_range(0, 9);
            if (op <= 5) wr(8'($urandom_range(0, NREG + 15)), 8'($urandom), "R2 R6 random write");
            else if (op == 6) wr(CTRL, LCK, "R6 random lock");
            else if (op == 7) wr(CTRL, ULK, "R7 R8 random unlock");
            else if (op == 8) begin
                for (int k = 0; k < 3; k++) send(non_pfx(8'($urandom)));
                check("R3 random idle junk", 0);
            end else begin
                logic [7:0] c = 8'($urandom);
                if (c == PFX || c == WRC) c = 8'h01;
                send(PFX); send(c);
                for (int k = 0; k < 4; k++) send(non_pfx(8'($urandom)));
                check("R4 random unknown code", 0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule